// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that retires exactly one instruction on every rising clock edge. It runs a seven-instruction subset:

- register add and subtract, plus register and, or and signed set-less-than;
- OR with an immediate;
- word load and word store;
- branch when two registers are equal;
- absolute jump.

The core holds a 32-entry by 32-bit register file, an immediate extender, an ALU, a program counter, and word-addressed instruction and data memories as internal arrays. The instruction array is filled from outside before reset is released. Reads from the register file and from both memories are combinational. Every state element updates on the same clock edge.

Decoding happens in two levels. A main decoder looks at the opcode and sets these controls:

- the destination select (rd or rt);
- the operand select (register or immediate);
- the write-back select (memory or ALU);
- the register and memory write enables;
- the branch and jump flags;
- the extension mode;
- a 3-bit ALU operation class.

A local decoder then turns that class, together with the function field for register-type instructions, into the 3-bit ALU command. Debug outputs show the address of the instruction executing this cycle and the register write it is making.

Top module: `sc_core`

## Requirements
- R1: While the synchronous reset is high, dbg_pc reads 0 and dbg_we stays 0 (no register or memory write commits). The first cycle after release executes the instruction at address 0.
- R2: Opcode 000000 with function 100000 writes R[rs]+R[rt] to register rd. Function 100010 writes R[rs]-R[rt] to rd. Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 000000 with function 100100 writes R[rs] AND R[rt] to rd. Function 100101 writes their OR. Function 101010 writes 1 when R[rs] is less than R[rt] as signed values, and 0 otherwise.
- R4: Opcode 001101 writes R[rs] OR zero-extended imm16[15:0] to register rt, whatever the rd bits hold.
- R5: Opcode 100011 writes to rt the data word at byte address R[rs]+sign-extended imm16. Opcode 101011 stores R[rt] at that address and writes no register.
- R6: Opcode 000100 writes no register. It moves the PC to PC+4+(sign-extended imm16 shifted left by 2) when R[rs] equals R[rt], and to PC+4 otherwise. This includes backward offsets.
- R7: Opcode 000010 writes no register and moves the PC to {(PC+4)[31:28], target[25:0], 00}.
- R8: Register 0 always reads as zero. A write request addressed to it leaves it zero.
- R9: Any other opcode writes nothing and advances the PC by 4. Every non-branch, non-jump instruction also advances the PC by 4.
- R10: dbg_pc shows the address of the instruction executing this cycle. dbg_we, dbg_waddr and dbg_wdata show the register write it commits at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_we | output | 1 | High when this cycle commits a register write |
| dbg_waddr | output | 5 | Destination register of that write |
| dbg_wdata | output | 32 | Data of that write |

## Verification
The bench builds the core with a 32-word instruction array and an 8-word data array. The 24-word program therefore fits, and the store and load addresses land in the small data array.

The instruction array reaches the 92-byte jump target. The data array is enough for two separate stores to the same word, one reached through a positive offset and one through a negative offset, each read back by a load.

The register file stays at the 32 entries that the 5-bit fields address. This lets the program exercise register 0 and the high register numbers.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN = 32;

  typedef enum logic [5:0] {
    OPC_RTYPE = 6'b000000,
    OPC_ORI   = 6'b001101,
    OPC_LW    = 6'b100011,
    OPC_SW    = 6'b101011,
    OPC_BEQ   = 6'b000100,
    OPC_JMP   = 6'b000010
  } opcode_e;

  typedef enum logic [5:0] {
    FN_ADD = 6'b100000,
    FN_SUB = 6'b100010,
    FN_AND = 6'b100100,
    FN_OR  = 6'b100101,
    FN_SLT = 6'b101010
  } funct_e;

  // Bit 2 set means "let the function field choose".
  typedef enum logic [2:0] {
    CLS_ADD   = 3'b000,
    CLS_SUB   = 3'b001,
    CLS_OR    = 3'b010,
    CLS_RTYPE = 3'b100
  } alu_class_e;

  typedef enum logic [2:0] {
    CMD_ADD = 3'b000,
    CMD_SUB = 3'b001,
    CMD_AND = 3'b010,
    CMD_OR  = 3'b110,
    CMD_SLT = 3'b111
  } alu_cmd_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       opb_is_imm;
    logic       wb_from_mem;
    logic       reg_write;
    logic       mem_write;
    logic       branch;
    logic       jump;
    logic       ext_signed;
    alu_class_e alu_class;
  } ctl_t;

  function automatic logic [XLEN-1:0] extend_imm(input logic [15:0] imm,
                                                 input logic sign);
    logic [XLEN-17:0] fill;
    fill = (sign && imm[15]) ? '1 : '0;
    return {fill, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_cmd_e cmd,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (cmd)
      CMD_ADD: r = a + b;
      CMD_SUB: r = a - b;
      CMD_AND: r = a & b;
      CMD_OR:  r = a | b;
      CMD_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc_inc,
                                                    input logic [15:0] imm);
    logic [XLEN-1:0] off;
    off = extend_imm(imm, 1'b1);
    return pc_inc + {off[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc_inc,
                                                  input logic [25:0] tgt);
    return {pc_inc[XLEN-1:28], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '0;
    ctl.alu_class = CLS_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_class = CLS_RTYPE;
      end
      OPC_ORI: begin
        ctl.opb_is_imm = 1'b1;
        ctl.reg_write  = 1'b1;
        ctl.alu_class  = CLS_OR;
      end
      OPC_LW: begin
        ctl.opb_is_imm  = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_write   = 1'b1;
        ctl.ext_signed  = 1'b1;
      end
      OPC_SW: begin
        ctl.opb_is_imm = 1'b1;
        ctl.mem_write  = 1'b1;
        ctl.ext_signed = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch    = 1'b1;
        ctl.alu_class = CLS_SUB;
      end
      OPC_JMP: begin
        ctl.jump = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_core_pkg::*;
(
  input  alu_class_e alu_class,
  input  logic [5:0] funct,
  output alu_cmd_e   cmd
);

  always_comb begin
    if (alu_class[2]) begin
      case (funct)
        FN_ADD:  cmd = CMD_ADD;
        FN_SUB:  cmd = CMD_SUB;
        FN_AND:  cmd = CMD_AND;
        FN_OR:   cmd = CMD_OR;
        FN_SLT:  cmd = CMD_SLT;
        default: cmd = CMD_ADD;
      endcase
    end else begin
      case (alu_class)
        CLS_SUB: cmd = CMD_SUB;
        CLS_OR:  cmd = CMD_OR;
        default: cmd = CMD_ADD;
      endcase
    end
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_cmd_e       cmd,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [W-1:0]   res,
  output logic           zero
);

  always_comb begin
    res  = alu_eval(cmd, opa, opb);
    zero = (res == '0);
  end

  // R3: set-less-than produces only 0 or 1
  always_comb begin
    if (cmd == CMD_SLT) begin
      assert_slt_is_bool_R3: assert (res[W-1:1] == '0)
        else $error("slt result has upper bits set");
    end
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);

  logic [NREG-1:0][W-1:0] flat;

  // Entry 0 has no storage: it is tied to zero.
  assign flat[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : gen_entry
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) q <= wdata;
    end
    assign flat[g] = q;
  end

  assign rd_a = flat[ra_a];
  assign rd_b = flat[ra_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_we,
  output logic [4:0]  dbg_waddr,
  output logic [31:0] dbg_wdata
);

  localparam int IAW  = $clog2(IMEM_WORDS);
  localparam int DAW  = $clog2(DMEM_WORDS);
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  // Instruction store: filled from outside before reset release.
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
  end

  logic [XLEN-1:0] pc_q, pc_inc, pc_next, br_target, jmp_target;
  logic [XLEN-1:0] instr;
  logic [5:0]      inst_op, inst_funct;
  logic [RAW-1:0]  inst_rs, inst_rt, inst_rd, waddr;
  logic [15:0]     inst_imm;
  logic [25:0]     inst_tgt;
  ctl_t            ctl;
  alu_cmd_e        alu_cmd;
  logic [XLEN-1:0] bus_a, bus_b, imm_ext, alu_b, alu_res, mem_rdata, wb_data;
  logic            alu_zero, rf_we, mem_we, br_taken;
  logic [DAW-1:0]  dmem_idx;

  // Fetch and field split
  assign instr      = imem[pc_q[IAW+1:2]];
  assign inst_op    = instr[31:26];
  assign inst_rs    = instr[25:21];
  assign inst_rt    = instr[20:16];
  assign inst_rd    = instr[15:11];
  assign inst_funct = instr[5:0];
  assign inst_imm   = instr[15:0];
  assign inst_tgt   = instr[25:0];

  sc_main_dec u_main_dec (
    .opcode (inst_op),
    .ctl    (ctl)
  );

  sc_alu_dec u_alu_dec (
    .alu_class (ctl.alu_class),
    .funct     (inst_funct),
    .cmd       (alu_cmd)
  );

  assign waddr   = ctl.dst_is_rd ? inst_rd : inst_rt;
  assign rf_we   = ctl.reg_write & ~rst;
  assign mem_we  = ctl.mem_write & ~rst;

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_regfile (
    .clk   (clk),
    .we    (rf_we),
    .waddr (waddr),
    .wdata (wb_data),
    .ra_a  (inst_rs),
    .ra_b  (inst_rt),
    .rd_a  (bus_a),
    .rd_b  (bus_b)
  );

  assign imm_ext = extend_imm(inst_imm, ctl.ext_signed);
  assign alu_b   = ctl.opb_is_imm ? imm_ext : bus_b;

  sc_alu #(.W(XLEN)) u_alu (
    .cmd  (alu_cmd),
    .opa  (bus_a),
    .opb  (alu_b),
    .res  (alu_res),
    .zero (alu_zero)
  );

  // Data memory: word addressed by the ALU sum
  assign dmem_idx  = alu_res[DAW+1:2];
  assign mem_rdata = dmem[dmem_idx];

  always_ff @(posedge clk) begin
    if (mem_we) dmem[dmem_idx] <= bus_b;
  end

  assign wb_data = ctl.wb_from_mem ? mem_rdata : alu_res;

  // Next-address logic
  assign pc_inc     = pc_q + 32'd4;
  assign br_target  = branch_target(pc_inc, inst_imm);
  assign jmp_target = jump_target(pc_inc, inst_tgt);
  assign br_taken   = ctl.branch & alu_zero;

  always_comb begin
    if (ctl.jump)      pc_next = jmp_target;
    else if (br_taken) pc_next = br_target;
    else               pc_next = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc    = pc_q;
  assign dbg_we    = rf_we;
  assign dbg_waddr = waddr;
  assign dbg_wdata = wb_data;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], alu_res[1:0], alu_res[XLEN-1:DAW+2],
                         pc_q[1:0], pc_q[XLEN-1:IAW+2]};

  // R5: a store never also writes a register
  assert_store_no_regwrite_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !rf_we)
    else $error("store cycle also writes a register");

  // R6: instruction addresses stay word aligned
  assert_pc_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00)
    else $error("pc not word aligned");

  // R6: a taken branch lands on its target
  assert_taken_target_R6: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc_q == $past(br_target)))
    else $error("taken branch missed its target");

  // R9: straight-line instructions step the PC by one word
  assert_seq_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctl.branch && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4))
    else $error("sequential pc step wrong");

  // R8: register 0 reads back as zero
  always_comb begin
    if (!rst && inst_rs == '0) begin
      assert_r0_reads_zero_R8: assert (bus_a == '0)
        else $error("register 0 not zero");
    end
  end

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

  localparam real PERIOD = 4.0;
  localparam int  IWORDS = 32;
  localparam int  NPROG  = 24;
  localparam int  NSTEP  = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_wdata;
  logic        dbg_we;
  logic [4:0]  dbg_waddr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sc_core #(.IMEM_WORDS(IWORDS), .DMEM_WORDS(8)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .dbg_pc    (dbg_pc),
    .dbg_we    (dbg_we),
    .dbg_waddr (dbg_waddr),
    .dbg_wdata (dbg_wdata)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  localparam logic [5:0] ORI = 6'b001101, LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;

  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(ORI, 5'd0, 5'd1, 16'h0005),           //  0
    enc_i(ORI, 5'd0, 5'd2, 16'hFFFF),           //  4
    enc_r(5'd1, 5'd2, 5'd3, 6'b100000),         //  8 add
    enc_r(5'd1, 5'd2, 5'd4, 6'b100010),         // 12 sub
    enc_i(SW,  5'd0, 5'd3, 16'd12),             // 16
    enc_i(LW,  5'd0, 5'd5, 16'd12),             // 20
    enc_i(ORI, 5'd1, 5'd0, 16'h00F0),           // 24 write to r0
    enc_r(5'd0, 5'd1, 5'd6, 6'b100000),         // 28 add r6,r0,r1
    enc_i(BEQ, 5'd1, 5'd6, 16'd2),              // 32 taken -> 44
    enc_i(ORI, 5'd0, 5'd7, 16'h0BAD),           // 36 skipped
    enc_i(ORI, 5'd0, 5'd7, 16'h0BAD),           // 40 skipped
    enc_i(BEQ, 5'd1, 5'd2, 16'd5),              // 44 not taken
    enc_i(ORI, 5'd0, 5'd8, 16'd16),             // 48
    enc_i(SW,  5'd8, 5'd4, 16'hFFFC),           // 52 negative offset
    enc_i(LW,  5'd0, 5'd9, 16'd12),             // 56
    enc_r(5'd4, 5'd2, 5'd10, 6'b100100),        // 60 and
    enc_r(5'd1, 5'd2, 5'd11, 6'b100101),        // 64 or
    enc_r(5'd4, 5'd1, 5'd12, 6'b101010),        // 68 slt -> 1
    enc_r(5'd1, 5'd4, 5'd13, 6'b101010),        // 72 slt -> 0
    {6'b111111, 5'd1, 5'd14, 16'h1234},         // 76 unknown opcode
    {6'b000010, 26'd23},                        // 80 jump -> 92
    enc_i(ORI, 5'd0, 5'd7, 16'h0BAD),           // 84 skipped
    enc_i(ORI, 5'd0, 5'd7, 16'h0BAD),           // 88 skipped
    enc_i(BEQ, 5'd0, 5'd0, 16'hFFFF)            // 92 branch to itself
  };

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
  } step_t;

  localparam step_t TRACE [NSTEP] = '{
    '{32'd0,  1'b1, 5'd1,  32'h0000_0005},
    '{32'd4,  1'b1, 5'd2,  32'h0000_FFFF},
    '{32'd8,  1'b1, 5'd3,  32'h0001_0004},
    '{32'd12, 1'b1, 5'd4,  32'hFFFF_0006},
    '{32'd16, 1'b0, 5'd0,  32'h0},
    '{32'd20, 1'b1, 5'd5,  32'h0001_0004},
    '{32'd24, 1'b1, 5'd0,  32'h0000_00F5},
    '{32'd28, 1'b1, 5'd6,  32'h0000_0005},
    '{32'd32, 1'b0, 5'd0,  32'h0},
    '{32'd44, 1'b0, 5'd0,  32'h0},
    '{32'd48, 1'b1, 5'd8,  32'h0000_0010},
    '{32'd52, 1'b0, 5'd0,  32'h0},
    '{32'd56, 1'b1, 5'd9,  32'hFFFF_0006},
    '{32'd60, 1'b1, 5'd10, 32'h0000_0006},
    '{32'd64, 1'b1, 5'd11, 32'h0000_FFFF},
    '{32'd68, 1'b1, 5'd12, 32'h0000_0001},
    '{32'd72, 1'b1, 5'd13, 32'h0000_0000},
    '{32'd76, 1'b0, 5'd0,  32'h0},
    '{32'd80, 1'b0, 5'd0,  32'h0},
    '{32'd92, 1'b0, 5'd0,  32'h0},
    '{32'd92, 1'b0, 5'd0,  32'h0},
    '{32'd92, 1'b0, 5'd0,  32'h0}
  };

  function automatic string row_tag(input int k);
    case (k)
      0, 1, 10:               return "R4";
      2, 3:                   return "R2";
      4, 5, 11, 12:           return "R5";
      6, 7:                   return "R8";
      13, 14, 15, 16:         return "R3";
      17:                     return "R9";
      18:                     return "R7";
      default:                return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_step(input int k);
    string t;
    t = row_tag(k);
    check(t, $sformatf("step %0d pc (R10)", k), dbg_pc, TRACE[k].pc);
    check(t, $sformatf("step %0d we", k), {31'b0, dbg_we}, {31'b0, TRACE[k].we});
    if (TRACE[k].we) begin
      check(t, $sformatf("step %0d waddr", k), {27'b0, dbg_waddr}, {27'b0, TRACE[k].wa});
      check(t, $sformatf("step %0d wdata", k), dbg_wdata, TRACE[k].wd);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1;
    for (int i = 0; i < IWORDS; i++) u_dut.imem[i] = (i < NPROG) ? PROG[i] : 32'h0;

    // R1: reset state with a writing instruction at address 0
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pc in reset", dbg_pc, 32'd0);
    check("R1", "we in reset", {31'b0, dbg_we}, 32'd0);

    rst = 1'b0;
    #0.5;
    check_step(0);
    for (int k = 1; k < NSTEP; k++) begin
      @(negedge clk);
      check_step(k);
    end

    // R1: reset in mid-run returns to address 0 and blocks writes
    rst = 1'b1;
    @(negedge clk);
    check("R1", "pc after mid-run reset", dbg_pc, 32'd0);
    check("R1", "we during mid-run reset", {31'b0, dbg_we}, 32'd0);
    @(negedge clk);
    check("R1", "pc held in reset", dbg_pc, 32'd0);
    rst = 1'b0;
    #0.5;
    check("R1", "first instr after release we", {31'b0, dbg_we}, 32'd1);
    check("R1", "first instr after release data", dbg_wdata, 32'h0000_0005);
    @(negedge clk);
    check("R1", "pc steps after release", dbg_pc, 32'd4);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule